// File: doc/BRIEF.md
# Polled Serial Transmitter Shell with Output Pin Frame

This block is the I/O shell that sits between a small processor core and the eight output pins of a shared-pad tile. It holds an asynchronous serial transmitter (one start bit, eight data bits sent least significant bit first, one stop bit). Its bit time is set by a 16-bit divisor that the board drives onto the two 8-bit input ports. The core hands it a byte with a one-cycle load strobe. It learns when the transmitter can take the next byte by polling a busy flag, which the shell exports for the core's memory-mapped status word.

The shell also maps signals onto the output port. The serial line goes on bit 0, the core's halted flag on bit 1, and six bits of a core register on bits 7:2. When the tile is not selected, the whole port is driven to zero. The bidirectional port is used as an input only, so its output values and output enables are held at zero.

Top module: `uart_pin_shell`

## Requirements
- R1: The divisor is `{in_hi, in_lo}`: in_lo supplies bits 7:0 and in_hi supplies bits 15:8. Each serial bit lasts divisor+1 clock cycles.
- R2: A frame is one start bit at 0, then the eight data bits least significant bit first, then one stop bit at 1. The whole frame lasts 10*(divisor+1) cycles.
- R3: After reset, and whenever no frame is in progress, the serial line (out_port bit 0) is 1.
- R4: With ena high, out_port bit 1 equals core_halted and out_port bits 7:2 equal r5_bits[5:0].
- R5: While ena is low, out_port is 8'h00 regardless of the other inputs and of reset.
- R6: bidir_out and bidir_oe are always 8'h00.
- R7: tx_busy is 1 from the cycle after a load is accepted until the last stop-bit cycle. It is 0 in the cycle that follows.
- R8: A load strobe that arrives while tx_busy is 1 is ignored, and the frame in progress is sent unchanged.
- R9: The divisor is captured when a load is accepted. A change on the input ports during a frame does not alter that frame's bit time.
- R10: With ena high, core_halted high, r5_bits = 12 and the line idle, out_port reads 8'h33.
- R11: A load presented in the first cycle after tx_busy falls is accepted at once, and a new start bit follows with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ena | input | 1 | Tile selected; when low, the output port is forced to zero |
| in_lo | input | 8 | Divisor bits 7:0 |
| in_hi | input | 8 | Divisor bits 15:8 (bidirectional port, input side) |
| tx_load | input | 1 | One-cycle strobe from the core: send tx_byte |
| tx_byte | input | 8 | Byte to send |
| core_halted | input | 1 | Core halted flag, shown on out_port bit 1 |
| r5_bits | input | 6 | Register bits shown on out_port bits 7:2 |
| tx_busy | output | 1 | Transmitter busy, read by the core through MMIO |
| out_port | output | 8 | Output pins: {r5_bits, core_halted, serial line} |
| bidir_out | output | 8 | Bidirectional output values, always 0 |
| bidir_oe | output | 8 | Bidirectional output enables, always 0 |

## Verification
A load that is present at a clock edge shows up after that edge: tx_busy rises and the line drops to the start bit, so the bench calls the first sampling point cycle 0. Bit k occupies cycles k*(D+1) through k*(D+1)+D, and the bench samples the line in the middle of each bit at offset D/2. tx_busy is checked at every cycle of the frame, and cycle 10*(D+1) must show it low with the line high. The pin mapping is combinational, so those checks sample on the same falling edge at which their inputs were driven. All sampling happens on falling edges, and stimulus is changed only after the sample has been taken.

// File: rtl/uart_shell_pkg.sv
package uart_shell_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/baud_ticker.sv
module baud_ticker #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
    } tick_regs_t;

    tick_regs_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        tick = run && (r_q.cnt == r_q.div);
        if (restart) begin
            r_d.cnt = '0;
            r_d.div = div_in;          // divisor frozen for the whole frame
        end else if (!run || tick) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R1 / R9: the count never passes the captured divisor while running
    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (r_q.cnt <= r_q.div));
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
    import uart_shell_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic              tick,
    output logic              accept,
    output logic              busy,
    output logic              line
);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    typedef struct packed {
        tx_state_e         state;
        logic [DATA_W-1:0] shreg;
        logic [BIT_W-1:0]  bitn;
        logic              line;
    } tx_regs_t;

    tx_regs_t s_d, s_q;

    assign busy   = (s_q.state != TX_IDLE);
    assign accept = load && (s_q.state == TX_IDLE);
    assign line   = s_q.line;

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            TX_IDLE: begin
                s_d.line = 1'b1;
                if (load) begin
                    s_d.state = TX_START;
                    s_d.shreg = data;
                    s_d.line  = 1'b0;
                end
            end
            TX_START: begin
                if (tick) begin
                    s_d.state = TX_DATA;
                    s_d.bitn  = '0;
                    s_d.line  = s_q.shreg[0];
                end
            end
            TX_DATA: begin
                if (tick) begin
                    if (s_q.bitn == LAST_BIT) begin
                        s_d.state = TX_STOP;
                        s_d.line  = 1'b1;
                    end else begin
                        s_d.shreg = s_q.shreg >> 1;
                        s_d.line  = s_q.shreg[1];
                        s_d.bitn  = s_q.bitn + 1'b1;
                    end
                end
            end
            TX_STOP: begin
                if (tick) begin
                    s_d.state = TX_IDLE;
                    s_d.line  = 1'b1;
                end
            end
            default: s_d.state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.state <= TX_IDLE;
            s_q.shreg <= '0;
            s_q.bitn  <= '0;
            s_q.line  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    // R2: a frame always opens with a low start bit
    assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (line == 1'b0));
    // R3: the line rests high between frames
    assert_idle_line_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line);
    // R7: busy falls right after the final stop-bit cycle
    assert_stop_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == TX_STOP && tick) |=> !busy);
    // R8: a load during a frame leaves the shifted data alone
    assert_busy_load_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load && !tick) |=> $stable(s_q.shreg));
endmodule

// File: rtl/pin_frame.sv
module pin_frame #(
    parameter int PORT_W = 8,
    parameter int REG_W  = 6
) (
    input  logic              ena,
    input  logic              line,
    input  logic              halted,
    input  logic [REG_W-1:0]  reg_bits,
    output logic [PORT_W-1:0] out_port,
    output logic [PORT_W-1:0] bidir_out,
    output logic [PORT_W-1:0] bidir_oe
);
    localparam int USED_W = REG_W + 2;

    logic [USED_W-1:0] packed_pins;

    assign packed_pins = {reg_bits, halted, line};

    generate
        if (PORT_W > USED_W) begin : g_pad
            assign out_port = ena ? {{(PORT_W-USED_W){1'b0}}, packed_pins} : '0;
        end else begin : g_fit
            assign out_port = ena ? packed_pins[PORT_W-1:0] : '0;
        end
    endgenerate

    assign bidir_out = '0;
    assign bidir_oe  = '0;
endmodule

// File: rtl/uart_pin_shell.sv
module uart_pin_shell #(
    parameter int PORT_W = 8,
    parameter int DATA_W = 8,
    parameter int REG_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ena,
    input  logic [PORT_W-1:0] in_lo,
    input  logic [PORT_W-1:0] in_hi,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              core_halted,
    input  logic [REG_W-1:0]  r5_bits,
    output logic              tx_busy,
    output logic [PORT_W-1:0] out_port,
    output logic [PORT_W-1:0] bidir_out,
    output logic [PORT_W-1:0] bidir_oe
);
    localparam int DIV_W = 2 * PORT_W;

    logic [DIV_W-1:0] divisor;
    logic             accept;
    logic             tick;
    logic             line;

    assign divisor = {in_hi, in_lo};

    baud_ticker #(.DIV_W(DIV_W)) u_ticker (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .run     (tx_busy),
        .div_in  (divisor),
        .tick    (tick)
    );

    tx_serializer #(.DATA_W(DATA_W)) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tx_load),
        .data   (tx_byte),
        .tick   (tick),
        .accept (accept),
        .busy   (tx_busy),
        .line   (line)
    );

    pin_frame #(.PORT_W(PORT_W), .REG_W(REG_W)) u_pins (
        .ena       (ena),
        .line      (line),
        .halted    (core_halted),
        .reg_bits  (r5_bits),
        .out_port  (out_port),
        .bidir_out (bidir_out),
        .bidir_oe  (bidir_oe)
    );

    // R7: an accepted load makes busy visible on the next cycle
    assert_accept_sets_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && !tx_busy) |=> tx_busy);
endmodule

// File: tb/uart_pin_shell_test.sv
module uart_pin_shell_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ena = 1'b1;
    logic [7:0] in_lo = 8'h00;
    logic [7:0] in_hi = 8'h00;
    logic       tx_load = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       core_halted = 1'b0;
    logic [5:0] r5_bits = 6'h00;
    logic       tx_busy;
    logic [7:0] out_port;
    logic [7:0] bidir_out;
    logic [7:0] bidir_oe;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    uart_pin_shell uut (
        .clk(clk), .rst_n(rst_n), .ena(ena), .in_lo(in_lo), .in_hi(in_hi),
        .tx_load(tx_load), .tx_byte(tx_byte), .core_halted(core_halted),
        .r5_bits(r5_bits), .tx_busy(tx_busy), .out_port(out_port),
        .bidir_out(bidir_out), .bidir_oe(bidir_oe)
    );

    // {divisor, byte, expected cycles per bit}
    localparam logic [39:0] VECS [6] = '{
        {16'd0,    8'hA5, 16'd1},
        {16'd1,    8'h3C, 16'd2},
        {16'd3,    8'h50, 16'd4},
        {16'd7,    8'h81, 16'd8},
        {16'd2,    8'h00, 16'd3},
        {16'h0100, 8'hFF, 16'd257}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Called on a falling edge; leaves on the falling edge where busy must be low.
    task automatic send_frame(input logic [15:0] d, input logic [7:0] b,
                              input int per, input int glitch_at,
                              input logic [7:0] gbyte, input int chg_at,
                              input logic [15:0] new_d, input string req);
        bit busy_bad = 1'b0;
        in_lo   = d[7:0];
        in_hi   = d[15:8];
        tx_byte = b;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        for (int c = 0; c < 10 * per; c++) begin
            if (!tx_busy) busy_bad = 1'b1;
            if ((c % per) == (per / 2)) begin
                int  k = c / per;
                logic exp_bit = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : b[k-1];
                check(out_port[0] == exp_bit, req, {31'd0, out_port[0]}, {31'd0, exp_bit});
            end
            tx_load = (c == glitch_at);
            if (c == glitch_at) tx_byte = gbyte;
            if (c == chg_at) begin
                in_lo = new_d[7:0];
                in_hi = new_d[15:8];
            end
            @(negedge clk);
        end
        tx_load = 1'b0;
        check(!busy_bad, "R7 busy held through frame", {31'd0, busy_bad}, 32'd0);
        check(!tx_busy, "R7 busy low after stop", {31'd0, tx_busy}, 32'd0);
        check(out_port[0] == 1'b1, "R3 line idle after frame", {31'd0, out_port[0]}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        check(out_port == 8'h01, "R3 reset pins", {24'd0, out_port}, 32'h01);
        check(!tx_busy, "R7 reset busy", {31'd0, tx_busy}, 32'd0);
        ena = 1'b0;
        @(negedge clk);
        check(out_port == 8'h00, "R5 muted in reset", {24'd0, out_port}, 32'h00);
        ena = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);

        // vector table
        foreach (VECS[i]) begin
            send_frame(VECS[i][39:24], VECS[i][23:16], int'(VECS[i][15:0]),
                       -1, 8'h00, -1, 16'd0,
                       (VECS[i][39:32] != 8'd0) ? "R1 high divisor byte" : "R2 frame bits");
        end

        // R8: load during a frame is dropped
        send_frame(16'd3, 8'h31, 4, 5, 8'hCE, -1, 16'd0, "R8 load while busy");
        // R9: divisor change mid-frame ignored (bit time stays 4)
        send_frame(16'd3, 8'h32, 4, -1, 8'h00, 2, 16'd0, "R9 divisor held");
        // R11: immediate back-to-back frame, divisor now 0
        send_frame(16'd0, 8'h0A, 1, -1, 8'h00, -1, 16'd0, "R11 back-to-back");

        // pin mapping
        core_halted = 1'b0; r5_bits = 6'h2A;
        #1;
        check(out_port == 8'hA9, "R4 pin map", {24'd0, out_port}, 32'hA9);
        core_halted = 1'b1; r5_bits = 6'd12;
        #1;
        check(out_port == 8'h33, "R10 halt pattern", {24'd0, out_port}, 32'h33);
        ena = 1'b0; r5_bits = 6'h3F;
        #1;
        check(out_port == 8'h00, "R5 muted after reset", {24'd0, out_port}, 32'h00);
        check(bidir_out == 8'h00, "R6 bidir out", {24'd0, bidir_out}, 32'h00);
        check(bidir_oe == 8'h00, "R6 bidir oe", {24'd0, bidir_oe}, 32'h00);

        // R5: a frame sent while deselected keeps the port silent
        in_lo = 8'd3; in_hi = 8'd0; tx_byte = 8'h00; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        check(tx_busy && out_port == 8'h00, "R5 muted during frame",
              {23'd0, tx_busy, out_port}, 32'h100);
        ena = 1'b1;
        #1;
        check(out_port[0] == 1'b0, "R5 start bit visible once enabled",
              {31'd0, out_port[0]}, 32'd0);
        check(bidir_oe == 8'h00, "R6 bidir oe during frame", {24'd0, bidir_oe}, 32'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule